// File: doc/BRIEF.md
# Registered Dual-Lane Bus Transceiver

This block passes bytes between two bidirectional ports, called A and B, in two lanes of eight bits each. Each lane has its own controls and works on its own. An active-low enable and a direction bit decide which port the lane drives. For each direction, a select chooses the source: the live data on the opposite port, or a byte captured earlier into that lane's register for the opposite port.

Each lane has two registers, one per port, and each register has its own clock. A register captures its port on every rising edge of its clock, whatever the enable and direction inputs are set to. Software can therefore fill both registers while the lane is isolated, then replay the stored bytes later. Each tri-state pin is split into an input bus, an output bus and one output enable per port and per lane, so the block can be synthesized. The output paths are purely combinational. Only the registers depend on the clocks. An asynchronous active-low reset clears every register to zero.

Top module: `dual_lane_xcvr`

## Requirements
- R1: Lane i uses bits [8i+7:8i] of every data bus and bit i of every control, clock and enable vector. No control of one lane changes any output of the other lane.
- R2: While `oe_n[i]` is 1, both `a_oe[i]` and `b_oe[i]` are 0.
- R3: While `oe_n[i]` is 0 and `dir[i]` is 0, `a_oe[i]` is 1 and `b_oe[i]` is 0.
- R4: While `oe_n[i]` is 0 and `dir[i]` is 1, `b_oe[i]` is 1 and `a_oe[i]` is 0.
- R5: When `a_oe[i]` is 1, the lane's byte on `a_out` is the live `b_in` byte if `sel_ba[i]` is 0, and the stored B byte if `sel_ba[i]` is 1.
- R6: When `b_oe[i]` is 1, the lane's byte on `b_out` is the live `a_in` byte if `sel_ab[i]` is 0, and the stored A byte if `sel_ab[i]` is 1.
- R7: On each rising edge of `clk_ab[i]`, the A register of lane i loads the A port value. On each rising edge of `clk_ba[i]`, the B register loads the B port value. Both loads happen for every setting of the enable and direction inputs, including isolation.
- R8: When a lane drives a port, that port's register captures the value the lane drives. When the lane does not drive the port, the register captures the external input.
- R9: When `rst_n` is low, every register of both lanes is cleared to zero at once, without waiting for a clock.
- R10: The output data and enables follow changes on the data and control inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all registers |
| clk_ab | input | 2 | Per-lane capture clock for the A register |
| clk_ba | input | 2 | Per-lane capture clock for the B register |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 0 drives A, 1 drives B |
| sel_ab | input | 2 | Per-lane B-port source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-lane A-port source: 0 live B, 1 stored B |
| a_in | input | 16 | Value seen on the A pins |
| a_out | output | 16 | Value offered to the A pins |
| a_oe | output | 2 | Per-lane drive enable for the A pins |
| b_in | input | 16 | Value seen on the B pins |
| b_out | output | 16 | Value offered to the B pins |
| b_oe | output | 2 | Per-lane drive enable for the B pins |

## Verification
The only internal state is the stored bytes. A wrong stored byte stays hidden until its lane drives the opposite port with the stored source selected. It then shows up on that output at once, with no clock needed, and it stays wrong until the next capture. For this reason the reference model tracks every capture, and the stored paths are read back after each capture, including captures made during isolation or while the lane drives that port. A wrong enable or a wrong live path shows up at the ports in the same cycle as the input change.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } lane_ctrl_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);

    logic [W-1:0] a_seen;
    logic [W-1:0] b_seen;

    always_comb begin
        a_oe  = !ctrl.oe_n && !ctrl.dir;
        b_oe  = !ctrl.oe_n &&  ctrl.dir;
        a_out = ctrl.sel_ba ? b_q : b_in;
        b_out = ctrl.sel_ab ? a_q : a_in;
        // a driven port's register sees the lane's own drive
        a_seen = a_oe ? a_out : a_in;
        b_seen = b_oe ? b_out : b_in;
    end

    xcvr_capture_reg #(.W(W)) a_reg_i (
        .clk(clk_ab), .rst_n(rst_n), .d(a_seen), .q(a_q)
    );

    xcvr_capture_reg #(.W(W)) b_reg_i (
        .clk(clk_ba), .rst_n(rst_n), .d(b_seen), .q(b_q)
    );

endmodule

// File: rtl/dual_lane_xcvr.sv
module dual_lane_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANES = 2,
    parameter int W     = 8
) (
    input  logic                 rst_n,
    input  logic [LANES-1:0]     clk_ab,
    input  logic [LANES-1:0]     clk_ba,
    input  logic [LANES-1:0]     oe_n,
    input  logic [LANES-1:0]     dir,
    input  logic [LANES-1:0]     sel_ab,
    input  logic [LANES-1:0]     sel_ba,
    input  logic [LANES*W-1:0]   a_in,
    output logic [LANES*W-1:0]   a_out,
    output logic [LANES-1:0]     a_oe,
    input  logic [LANES*W-1:0]   b_in,
    output logic [LANES*W-1:0]   b_out,
    output logic [LANES-1:0]     b_oe
);

    localparam int BUS_W = LANES * W;

    logic [BUS_W-1:0] a_q_all;
    logic [BUS_W-1:0] b_q_all;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t ctrl;
        assign ctrl = '{oe_n: oe_n[g], dir: dir[g],
                        sel_ab: sel_ab[g], sel_ba: sel_ba[g]};

        xcvr_lane #(.W(W)) lane_i (
            .rst_n (rst_n),
            .clk_ab(clk_ab[g]),
            .clk_ba(clk_ba[g]),
            .ctrl  (ctrl),
            .a_in  (a_in[g*W +: W]),
            .b_in  (b_in[g*W +: W]),
            .a_out (a_out[g*W +: W]),
            .a_oe  (a_oe[g]),
            .b_out (b_out[g*W +: W]),
            .b_oe  (b_oe[g]),
            .a_q   (a_q_all[g*W +: W]),
            .b_q   (b_q_all[g*W +: W])
        );
    end

endmodule

// File: rtl/dual_lane_xcvr_chk.sv
module dual_lane_xcvr_chk #(
    parameter int LANES = 2,
    parameter int W     = 8
) (
    input logic               rst_n,
    input logic [LANES-1:0]   clk_ab,
    input logic [LANES-1:0]   clk_ba,
    input logic [LANES-1:0]   oe_n,
    input logic [LANES-1:0]   dir,
    input logic [LANES-1:0]   sel_ab,
    input logic [LANES-1:0]   sel_ba,
    input logic [LANES*W-1:0] a_in,
    input logic [LANES*W-1:0] b_in,
    input logic [LANES*W-1:0] a_out,
    input logic [LANES*W-1:0] b_out,
    input logic [LANES-1:0]   a_oe,
    input logic [LANES-1:0]   b_oe,
    input logic [LANES*W-1:0] a_q_all,
    input logic [LANES*W-1:0] b_q_all
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R2
        isolate_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            oe_n[g] |-> (!a_oe[g] && !b_oe[g]));

        // R3
        drive_a_chk: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            (!oe_n[g] && !dir[g]) |-> (a_oe[g] && !b_oe[g]));

        // R4
        drive_b_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            (!oe_n[g] && dir[g]) |-> (b_oe[g] && !a_oe[g]));

        // R6
        stored_ab_chk: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            (b_oe[g] && sel_ab[g]) |-> (b_out[g*W +: W] == a_q_all[g*W +: W]));

        // R5
        stored_ba_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            (a_oe[g] && sel_ba[g]) |-> (a_out[g*W +: W] == b_q_all[g*W +: W]));

        // R5
        live_ba_chk: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            (a_oe[g] && !sel_ba[g]) |-> (a_out[g*W +: W] == b_in[g*W +: W]));
    end

endmodule

bind dual_lane_xcvr dual_lane_xcvr_chk #(.LANES(LANES), .W(W)) chk_i (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
    .a_q_all(a_q_all), .b_q_all(b_q_all)
);

// File: tb/dual_lane_xcvr_tb_top.sv
module dual_lane_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;

    logic [7:0]  m_a [2];
    logic [7:0]  m_b [2];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_lane_xcvr dut_i (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_a_oe(int l); return !oe_n[l] && !dir[l]; endfunction
    function automatic logic m_b_oe(int l); return !oe_n[l] &&  dir[l]; endfunction
    function automatic logic [7:0] m_a_out(int l);
        if (sel_ba[l]) return m_b[l];
        return b_in[l*8 +: 8];
    endfunction
    function automatic logic [7:0] m_b_out(int l);
        if (sel_ab[l]) return m_a[l];
        return a_in[l*8 +: 8];
    endfunction

    task automatic compare_all();
        for (int l = 0; l < 2; l++) begin
            string t = oe_n[l] ? "R2" : (dir[l] ? "R4" : "R3");
            check({t, " a_oe"}, {7'd0, a_oe[l]}, {7'd0, m_a_oe(l)});
            check({t, " b_oe"}, {7'd0, b_oe[l]}, {7'd0, m_b_oe(l)});
            if (m_a_oe(l)) check(sel_ba[l] ? "R5 R7 stored a_out" : "R5 live a_out",
                                 a_out[l*8 +: 8], m_a_out(l));
            if (m_b_oe(l)) check(sel_ab[l] ? "R6 R7 stored b_out" : "R6 live b_out",
                                 b_out[l*8 +: 8], m_b_out(l));
        end
    endtask

    // called just after a falling edge of clk with inputs already applied
    task automatic step(input logic [1:0] cab, input logic [1:0] cba);
        logic [7:0] na [2];
        logic [7:0] nb [2];
        #2;
        for (int l = 0; l < 2; l++) begin
            na[l] = m_a_oe(l) ? m_a_out(l) : a_in[l*8 +: 8];
            nb[l] = m_b_oe(l) ? m_b_out(l) : b_in[l*8 +: 8];
        end
        clk_ab = cab;
        clk_ba = cba;
        for (int l = 0; l < 2; l++) begin
            if (cab[l]) m_a[l] = na[l];
            if (cba[l]) m_b[l] = nb[l];
        end
        #1;
        compare_all();
        @(negedge clk);
        clk_ab = 2'b00;
        clk_ba = 2'b00;
    endtask

    task automatic set_lane(input int l, input logic [3:0] c);
        {oe_n[l], dir[l], sel_ab[l], sel_ba[l]} = c;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] h1a, h1b;
        rst_n = 0; clk_ab = 0; clk_ba = 0;
        oe_n = 2'b11; dir = 0; sel_ab = 0; sel_ba = 0;
        a_in = 16'hA5C3; b_in = 16'h3C5A;
        for (int l = 0; l < 2; l++) begin m_a[l] = 0; m_b[l] = 0; end
        repeat (2) @(negedge clk);
        rst_n = 1;

        // R9: stored bytes read back as zero after reset
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #1;
        check("R9 A reg lane0", b_out[7:0], 8'h00);
        check("R9 A reg lane1", b_out[15:8], 8'h00);
        dir = 2'b00; sel_ba = 2'b11;
        #1;
        check("R9 B reg lane0", a_out[7:0], 8'h00);
        check("R9 B reg lane1", a_out[15:8], 8'h00);
        @(negedge clk);

        // R7: capture while isolated
        oe_n = 2'b11; a_in = 16'h3C96; b_in = 16'h1E77;
        step(2'b11, 2'b11);
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #1;
        check("R7 isolated capture A lane0", b_out[7:0], 8'h96);
        check("R7 isolated capture A lane1", b_out[15:8], 8'h3C);
        dir = 2'b00; sel_ba = 2'b11;
        #1;
        check("R7 isolated capture B lane0", a_out[7:0], 8'h77);
        @(negedge clk);

        // R8: A register takes the lane's own drive, not the external A input
        oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b00; sel_ab = 2'b00;
        a_in = 16'hFFFF; b_in = 16'h445A;
        step(2'b01, 2'b00);
        dir = 2'b01; sel_ab = 2'b01;
        #1;
        check("R8 driven value captured", b_out[7:0], 8'h5A);
        @(negedge clk);

        // R10: live path follows input with no clock edge
        oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b00; b_in = 16'h1234;
        #1; check("R10 live follow 1", a_out[7:0], 8'h34);
        b_in = 16'h12C8;
        #1; check("R10 live follow 2", a_out[7:0], 8'hC8);
        oe_n[0] = 1'b1;
        #1; check("R10 enable follows", {7'd0, a_oe[0]}, 8'h00);
        @(negedge clk);

        // R1: sweep lane 0 controls, lane 1 outputs must not move
        set_lane(1, 4'b0010);
        #1; h1a = a_out[15:8]; h1b = {6'd0, b_oe[1], a_oe[1]};
        for (int c = 0; c < 16; c++) begin
            set_lane(0, c[3:0]);
            #1;
            check("R1 lane1 a_out stable", a_out[15:8], h1a);
            check("R1 lane1 enables stable", {6'd0, b_oe[1], a_oe[1]}, h1b);
        end
        @(negedge clk);

        // every control combination, both lanes, varied clocks
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 16; c++) begin
                set_lane(0, c[3:0]);
                set_lane(1, 4'(15 - c));
                a_in = 16'($urandom); b_in = 16'($urandom);
                step(2'($urandom), 2'($urandom));
            end
        end

        // random traffic with a mid-run asynchronous reset
        for (int n = 0; n < 400; n++) begin
            {oe_n, dir, sel_ab, sel_ba} = 8'($urandom);
            a_in = 16'($urandom); b_in = 16'($urandom);
            if (n == 200) begin
                #1; rst_n = 0;
                for (int l = 0; l < 2; l++) begin m_a[l] = 0; m_b[l] = 0; end
                #1; compare_all();
                @(negedge clk); rst_n = 1;
            end
            step(2'($urandom), 2'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule